// File: doc/BRIEF.md
# Clustering pixel-region readout arbiter

This block drains one double-pixel core column of binary hit flags. The column is a stack of pixel regions, each two pixels wide and four rows tall. Every region is split into a 2x2 master quad, which can send packets, and a 2x2 slave quad, which cannot. A slave quad rides along in the packet of a master. That master is its own region's master when that master quad has hits. Otherwise it is the master of the next region up the stack. As a result, a cluster that crosses a region boundary usually leaves in one packet instead of two.

Hit flags are captured into per-region registers on a latch strobe, and only while nothing is pending. A combinational token chain then picks the lowest-addressed master with work. Its address and 8-bit hit map stay on the output until an acknowledge retires them. Retiring a packet clears the bits it carried. The next pending master appears on the following cycle, and empty regions cost no cycles.

Top module: `cluster_readout`

## Requirements
- R1: After reset `pkt_valid` is low and no region holds hits.
- R2: A `latch_stb` seen while `pkt_valid` is low loads `hit_in` (region i in bits [8i+7:8i], master quad in the low nibble, slave quad in the high nibble). If any master then has work, `pkt_valid` is high from the next cycle.
- R3: A `latch_stb` seen while `pkt_valid` is high is ignored: the captured hits are unchanged and the new ones never appear.
- R4: A slave quad whose own master quad has hits is sent with that master. The packet carries the region's address, `pkt_map[3:0]` = master quad, `pkt_map[7:4]` = slave quad, and `pkt_low_slave` = 0.
- R5: A hit slave quad of region i whose master quad is empty, with i below the top region, is sent by the master of region i+1. The packet carries address i+1, `pkt_map[7:4]` = slave quad of region i, `pkt_map[3:0]` = master quad of region i+1, and `pkt_low_slave` = 1.
- R6: In the top region (address N_REG-1) a hit slave quad with an empty master quad is sent at its own address, with `pkt_low_slave` = 0 and `pkt_map[3:0]` = 0.
- R7: A master with no hits and no attached slave is never addressed. After an acknowledge, the next pending packet is presented in the very next cycle, however many empty regions lie between.
- R8: Pending masters are served in ascending address order.
- R9: When a master has its own slave attached and also the slave from the region below, its first packet carries its own quad and own slave. A later packet at the same address carries the lower slave, with `pkt_map[3:0]` = 0 and `pkt_low_slave` = 1.
- R10: While `ack` is low, `pkt_valid`, `pkt_addr`, `pkt_map` and `pkt_low_slave` hold their values. An `ack` while `pkt_valid` is low has no effect.
- R11: An `ack` with `pkt_valid` high clears exactly the quads carried in the presented packet. Every hit pixel leaves in exactly one packet, and `pkt_map` is never zero while valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | N_REG*8 | Hit flags of all regions, 8 bits per region |
| latch_stb | input | 1 | Capture `hit_in` into the region registers when idle |
| ack | input | 1 | Retire the presented packet |
| pkt_valid | output | 1 | A packet is presented |
| pkt_addr | output | clog2(N_REG) | Address of the serving master's region |
| pkt_map | output | 8 | Slave quad in [7:4], master quad in [3:0] |
| pkt_low_slave | output | 1 | 1 when the slave nibble comes from the region below |

## Verification
Single-region hits with and without a master quad show whether a slave attaches upward or downward. The top region's lone slave shows the boundary rule that keeps it at its own address. A master carrying two slaves shows the order in which they go out. Hits scattered across widely separated regions, drained back to back, show address order and that empty regions are skipped without gaps. Random sparse hit maps with random acknowledge and stray latch strobes are checked every cycle against a behavioural grouping model, which exposes lost, duplicated or misattributed quads.

// File: rtl/rcl_pkg.sv
`timescale 1ns/1ps
package rcl_pkg;
    localparam int QUAD_W = 4;
    localparam int MAP_W  = 2 * QUAD_W;

    typedef logic [QUAD_W-1:0] quad_t;

    // One region: slave quad in the upper nibble, master quad in the lower.
    typedef struct packed {
        quad_t slave;
        quad_t master;
    } region_t;

    // Packet content selected from the winning region.
    typedef struct packed {
        logic  low;
        quad_t slave;
        quad_t master;
    } pick_t;

    function automatic logic quad_hit(quad_t q);
        return |q;
    endfunction
endpackage

// File: rtl/rcl_region_store.sv
`timescale 1ns/1ps
module rcl_region_store
    import rcl_pkg::*;
#(
    parameter int N_REG = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [N_REG*MAP_W-1:0]    hit_in,
    input  logic [N_REG-1:0]          clr_master,
    input  logic [N_REG-1:0]          clr_slave,
    output region_t [N_REG-1:0]       regs
);
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        region_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (load) begin
                q <= region_t'(hit_in[g*MAP_W +: MAP_W]);
            end else begin
                if (clr_master[g]) q.master <= '0;
                if (clr_slave[g])  q.slave  <= '0;
            end
        end
        assign regs[g] = q;
    end
endmodule

// File: rtl/rcl_assign.sv
`timescale 1ns/1ps
module rcl_assign
    import rcl_pkg::*;
#(
    parameter int N_REG = 64
) (
    input  region_t [N_REG-1:0] regs,
    output logic [N_REG-1:0]    carry_own,
    output logic [N_REG-1:0]    carry_low,
    output logic [N_REG-1:0]    pend
);
    for (genvar g = 0; g < N_REG; g++) begin : g_asn
        logic m_hit, s_hit, up_ok, from_below;
        assign m_hit = quad_hit(regs[g].master);
        assign s_hit = quad_hit(regs[g].slave);
        // The top region has no master above, so its slave stays home.
        if (g == N_REG-1) begin : g_top
            assign up_ok = 1'b1;
        end else begin : g_mid
            assign up_ok = m_hit;
        end
        // The slave below is handed up when its own master is empty.
        if (g == 0) begin : g_first
            assign from_below = 1'b0;
        end else begin : g_rest
            assign from_below = quad_hit(regs[g-1].slave) & ~quad_hit(regs[g-1].master);
        end
        assign carry_own[g] = up_ok & s_hit;
        assign carry_low[g] = from_below & ~carry_own[g];
        assign pend[g]      = m_hit | carry_own[g] | carry_low[g];
    end
endmodule

// File: rtl/rcl_token_chain.sv
`timescale 1ns/1ps
module rcl_token_chain #(
    parameter int N_REG  = 64,
    parameter int ADDR_W = 6
) (
    input  logic [N_REG-1:0]  pend,
    output logic [N_REG-1:0]  grant,
    output logic [ADDR_W-1:0] addr,
    output logic              any
);
    logic [N_REG:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N_REG; g++) begin : g_tok
        assign grant[g]    = pend[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | pend[g];
    end
    assign any = seen[N_REG];

    always_comb begin
        addr = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (grant[i]) addr = addr | ADDR_W'(i);
        end
    end
endmodule

// File: rtl/cluster_readout.sv
`timescale 1ns/1ps
module cluster_readout
    import rcl_pkg::*;
#(
    parameter  int N_REG  = 64,
    localparam int ADDR_W = $clog2(N_REG),
    localparam int HIT_W  = N_REG * MAP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIT_W-1:0]  hit_in,
    input  logic              latch_stb,
    input  logic              ack,
    output logic              pkt_valid,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [MAP_W-1:0]  pkt_map,
    output logic              pkt_low_slave
);
    region_t [N_REG-1:0] regs;
    logic [N_REG-1:0]    carry_own, carry_low, pend, grant, clr_m, clr_s;
    logic                any, load, retire;
    logic [ADDR_W-1:0]   sel;
    pick_t               contrib [N_REG];
    pick_t               pick;

    assign load   = latch_stb & ~any;
    assign retire = ack & any;
    assign clr_m  = {N_REG{retire}} & grant;

    rcl_region_store #(.N_REG(N_REG)) u_store (
        .clk(clk), .rst(rst), .load(load), .hit_in(hit_in),
        .clr_master(clr_m), .clr_slave(clr_s), .regs(regs)
    );

    rcl_assign #(.N_REG(N_REG)) u_assign (
        .regs(regs), .carry_own(carry_own), .carry_low(carry_low), .pend(pend)
    );

    rcl_token_chain #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_token (
        .pend(pend), .grant(grant), .addr(sel), .any(any)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_sel
        if (g == 0) begin : g_base
            assign contrib[g] = grant[g] ?
                pick_t'{low: 1'b0,
                        slave: carry_own[g] ? regs[g].slave : '0,
                        master: regs[g].master} : '0;
        end else begin : g_up
            assign contrib[g] = grant[g] ?
                pick_t'{low: carry_low[g],
                        slave: carry_own[g] ? regs[g].slave :
                               (carry_low[g] ? regs[g-1].slave : '0),
                        master: regs[g].master} : '0;
        end
        // A slave is cleared by whichever master carried it.
        if (g == N_REG-1) begin : g_clr_top
            assign clr_s[g] = retire & grant[g] & carry_own[g];
        end else begin : g_clr_mid
            assign clr_s[g] = retire & ((grant[g] & carry_own[g]) |
                                        (grant[g+1] & carry_low[g+1]));
        end
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_REG; i++) pick = pick | contrib[i];
    end

    assign pkt_valid     = any;
    assign pkt_addr      = sel;
    assign pkt_map       = {pick.slave, pick.master};
    assign pkt_low_slave = pick.low;
endmodule

// File: rtl/cluster_readout_chk.sv
`timescale 1ns/1ps
module cluster_readout_chk #(
    parameter int N_REG  = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [N_REG*8-1:0] hit_in,
    input logic              latch_stb,
    input logic              ack,
    input logic              pkt_valid,
    input logic [ADDR_W-1:0] pkt_addr,
    input logic [7:0]        pkt_map,
    input logic              pkt_low_slave
);
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (latch_stb && !pkt_valid && (hit_in != '0)) |=> pkt_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !ack) |=> (pkt_valid && $stable(pkt_addr) &&
                                 $stable(pkt_map) && $stable(pkt_low_slave)));

    p_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_map != 8'h00));

    p_low_slave_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_low_slave) |-> ((pkt_map[7:4] != 4'h0) && (pkt_addr != '0)));

    p_order_r8: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && ack) |=> (!pkt_valid || (pkt_addr >= $past(pkt_addr))));
endmodule

bind cluster_readout cluster_readout_chk #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .hit_in(hit_in), .latch_stb(latch_stb), .ack(ack),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_map(pkt_map),
    .pkt_low_slave(pkt_low_slave)
);

// File: tb/cluster_readout_tb.sv
`timescale 1ns/1ps
module cluster_readout_tb;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*8-1:0] hit_in = '0;
    logic           latch_stb = 1'b0;
    logic           ack = 1'b0;
    logic           pkt_valid;
    logic [5:0]     pkt_addr;
    logic [7:0]     pkt_map;
    logic           pkt_low_slave;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [N*8-1:0] vec;

    logic [3:0] mm [N];
    logic [3:0] ms [N];

    always #2 clk = ~clk;

    cluster_readout u_dut (
        .clk(clk), .rst(rst), .hit_in(hit_in), .latch_stb(latch_stb), .ack(ack),
        .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_map(pkt_map),
        .pkt_low_slave(pkt_low_slave)
    );

    // Behavioural grouping model: {valid, low, addr[5:0], slave, master}
    function automatic logic [15:0] ref_pkt();
        for (int i = 0; i < N; i++) begin
            logic own, low;
            own = ((mm[i] != 0) || (i == N-1)) && (ms[i] != 0);
            low = !own && (i > 0) && (mm[i-1] == 0) && (ms[i-1] != 0);
            if ((mm[i] != 0) || own || low)
                return {1'b1, low, 6'(i), own ? ms[i] : (low ? ms[i-1] : 4'h0), mm[i]};
        end
        return 16'h0;
    endfunction

    always @(posedge clk) begin
        logic [15:0] p;
        if (rst) begin
            for (int i = 0; i < N; i++) begin mm[i] = 0; ms[i] = 0; end
        end else begin
            p = ref_pkt();
            if (ack && p[15]) begin
                int a;
                a = int'(p[13:8]);
                mm[a] = 0;
                if (p[14]) ms[a-1] = 0;
                else if (p[7:4] != 0) ms[a] = 0;
            end else if (latch_stb && !p[15]) begin
                for (int i = 0; i < N; i++) {ms[i], mm[i]} = hit_in[i*8 +: 8];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R11: each hit in exactly one packet)
    always @(negedge clk) begin
        logic [15:0] e;
        if (!rst && !done) begin
            e = ref_pkt();
            if (e[15])
                chk("R11 model", {16'h0, pkt_valid, pkt_low_slave, pkt_addr, pkt_map}, {16'h0, e});
            else
                chk("R11 model idle", {31'h0, pkt_valid}, 32'h0);
        end
    end

    task automatic expect_pkt(string tag, int a, logic [7:0] m, logic low);
        chk(tag, {22'h0, pkt_valid, pkt_low_slave, pkt_addr, pkt_map},
                 {22'h0, 1'b1, low, 6'(a), m});
    endtask

    task automatic expect_idle(string tag);
        chk(tag, {31'h0, pkt_valid}, 32'h0);
    endtask

    task automatic put(int idx, logic [3:0] m, logic [3:0] s);
        vec[idx*8 +: 8] = {s, m};
    endtask

    // All tasks start and end just after a falling edge.
    task automatic latch_hits(logic [N*8-1:0] v);
        hit_in = v; latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1 reset idle");

        // R4: own-master attach
        vec = '0; put(3, 4'b0001, 4'b1000);
        latch_hits(vec);
        expect_pkt("R2 R4 own slave", 3, 8'h81, 1'b0);
        ack_pulse();
        expect_idle("R11 cleared after R4");

        // R5: slave hands up to the next master
        vec = '0; put(5, 4'b0000, 4'b0110); put(6, 4'b0010, 4'b0000);
        latch_hits(vec);
        expect_pkt("R5 lower slave", 6, 8'h62, 1'b1);
        ack_pulse();
        expect_idle("R11 cleared after R5");

        // R6: top region keeps its slave
        vec = '0; put(63, 4'b0000, 4'b0101);
        latch_hits(vec);
        expect_pkt("R6 top slave", 63, 8'h50, 1'b0);
        ack_pulse();
        expect_idle("R11 cleared after R6");

        // R7, R8: order and no gaps
        vec = '0; put(10, 4'h1, 4'h0); put(40, 4'h2, 4'h0); put(2, 4'h4, 4'h0);
        latch_hits(vec);
        expect_pkt("R8 first lowest", 2, 8'h04, 1'b0);
        ack_pulse();
        expect_pkt("R7 next without gap", 10, 8'h01, 1'b0);
        ack_pulse();
        expect_pkt("R8 last", 40, 8'h02, 1'b0);
        ack_pulse();
        expect_idle("R7 drained");

        // R9: master carrying two slaves
        vec = '0; put(7, 4'h0, 4'h3); put(8, 4'h1, 4'h2);
        latch_hits(vec);
        expect_pkt("R9 own slave first", 8, 8'h21, 1'b0);
        ack_pulse();
        expect_pkt("R9 lower slave later", 8, 8'h30, 1'b1);
        ack_pulse();
        expect_idle("R9 drained");

        // R3: latch while pending is ignored
        vec = '0; put(1, 4'h1, 4'h0);
        latch_hits(vec);
        vec = '0; put(20, 4'h1, 4'h0);
        latch_hits(vec);
        expect_pkt("R3 old packet kept", 1, 8'h01, 1'b0);
        ack_pulse();
        expect_idle("R3 new hits not captured");

        // R10: ack while idle, then hold without ack
        ack_pulse();
        expect_idle("R10 idle ack");
        vec = '0; put(12, 4'h3, 4'h0);
        latch_hits(vec);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_pkt("R10 hold", 12, 8'h03, 1'b0);
        end
        ack_pulse();
        expect_idle("R10 retired");

        // Random sparse maps, random ack and stray strobes
        for (int r = 0; r < 120; r++) begin
            vec = '0;
            for (int i = 0; i < N; i++)
                if ($urandom % 5 == 0) vec[i*8 +: 8] = 8'($urandom);
            latch_hits(vec);
            for (int c = 0; c < 30; c++) begin
                ack = 1'($urandom % 2);
                latch_stb = ($urandom % 4 == 0);
                hit_in = {N{8'($urandom)}};
                @(negedge clk);
            end
            latch_stb = 1'b0;
            ack = 1'b1;
            for (int c = 0; c < 200 && pkt_valid; c++) @(negedge clk);
            ack = 1'b0;
            expect_idle("R11 random drain");
        end

        finish_run();
    end
endmodule